// File: doc/BRIEF.md
# CAN Bit Destuffer

The destuffer sits between a CAN bit sampler and the frame parser. Every sampled bus bit arrives with a one-cycle strobe. The block keeps a short history of the raw bits and recognises stuff bits, which the transmitter inserts after a run of equal bits. It removes those stuff bits so that the parser sees only true frame bits, each tagged with its position in the frame. Position 0 is the start-of-frame bit.

Stuff bits are still reported, on a strobe of their own, so that they can be observed. Once the parser has decoded the data length, it reports the index of the last data bit. From a fixed distance past that index, the frame has its fixed-form tail: the CRC delimiter, the acknowledge field and the end-of-frame field. Destuffing is switched off there. A frame reset starts each new frame. Checking for stuff errors is not part of this block.

Top module: `can_destuff`

## Requirements
- R1: A raw bit is a stuff bit when the RUN_LEN (default 5) raw bits before it are all equal and it has the opposite value. With the default, the last six raw bits then read 000001 or 111110.
- R2: A stuff bit raises `stuff_vld` instead of `bit_vld`. It does not advance the frame index, and the next frame bit carries the index that the stuff bit reported.
- R3: A stuff bit stays in the raw history. It therefore counts as the first bit of the run that the next detection examines.
- R4: Until RUN_LEN raw bits have been received since reset or since the last frame reset, no bit is treated as stuff.
- R5: The first frame bit after a frame reset carries index 0. Each following frame bit carries the previous index plus one.
- R6: `frame_clr` clears the history, the index and the stored last-data-bit index. A raw strobe in the same cycle is dropped and produces no output.
- R7: Once a last-data-bit index L is known, a raw bit whose frame index is L+17 (TAIL_GAP) or greater is never treated as stuff. At index L+16 detection is still active.
- R8: Before `last_vld` has pulsed in a frame, the threshold is infinite. The value is taken only on `last_vld`; later changes to `last_idx` have no effect.
- R9: `bit_vld` or `stuff_vld` pulses exactly one cycle after each accepted `raw_vld`, never both at once and never without a strobe. `bit_out` equals the raw bit.
- R10: After reset, `bit_vld` and `stuff_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_vld | input | 1 | Strobe: one sampled bus bit |
| raw_bit | input | 1 | Sampled bit value (0 = dominant) |
| frame_clr | input | 1 | Start a new frame (clears state) |
| last_vld | input | 1 | Strobe: `last_idx` is valid |
| last_idx | input | IDX_W | Frame index of the last data bit |
| bit_vld | output | 1 | Strobe: frame bit delivered |
| stuff_vld | output | 1 | Strobe: stuff bit seen and dropped |
| bit_out | output | 1 | Value of the bit just reported |
| bit_idx | output | IDX_W | Frame index of the reported bit |

## Verification
Every output is registered once, so a raw bit driven before a rising edge is reported in that edge's cycle. The bench drives each bit on a falling edge and reads all four outputs on the following falling edge, half a period after they change. A stored last-data-bit index takes effect from the next raw bit. The bench therefore pulses it in its own cycle before continuing the frame. The tail boundary is examined at both sides, L+16 and L+17. Each check is placed at the index where the requirement says the behaviour must change.

// File: rtl/can_destuff.sv
module can_destuff #(
  parameter int IDX_W    = 8,
  parameter int RUN_LEN  = 5,
  parameter int TAIL_GAP = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_vld,
  input  logic             raw_bit,
  input  logic             frame_clr,
  input  logic             last_vld,
  input  logic [IDX_W-1:0] last_idx,
  output logic             bit_vld,
  output logic             stuff_vld,
  output logic             bit_out,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0]  FULL = CW'(RUN_LEN);
  localparam logic [IDX_W:0] GAP  = (IDX_W+1)'(TAIL_GAP);

  logic [RUN_LEN-1:0] hist;
  logic [CW-1:0]      fill;
  logic [IDX_W-1:0]   fidx;
  logic [IDX_W-1:0]   last_q;
  logic               last_ok;

  wire run_eq   = (hist == '0) || (hist == '1);
  wire flips    = raw_bit != hist[0];
  wire in_tail  = last_ok && ({1'b0, fidx} >= ({1'b0, last_q} + GAP));
  wire is_stuff = raw_vld && (fill == FULL) && run_eq && flips && !in_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      fill      <= '0;
      fidx      <= '0;
      last_q    <= '0;
      last_ok   <= 1'b0;
      bit_vld   <= 1'b0;
      stuff_vld <= 1'b0;
      bit_out   <= 1'b0;
      bit_idx   <= '0;
    end else if (frame_clr) begin
      hist      <= '0;
      fill      <= '0;
      fidx      <= '0;
      last_ok   <= 1'b0;
      bit_vld   <= 1'b0;
      stuff_vld <= 1'b0;
    end else begin
      bit_vld   <= raw_vld && !is_stuff;
      stuff_vld <= is_stuff;
      if (last_vld) begin
        last_q  <= last_idx;
        last_ok <= 1'b1;
      end
      if (raw_vld) begin
        hist    <= {hist[RUN_LEN-2:0], raw_bit};
        if (fill != FULL) fill <= fill + 1'b1;
        bit_out <= raw_bit;
        bit_idx <= fidx;
        if (!is_stuff) fidx <= fidx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_destuff_chk.sv
module can_destuff_chk #(
  parameter int IDX_W   = 8,
  parameter int RUN_LEN = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raw_vld,
  input logic             frame_clr,
  input logic             bit_vld,
  input logic             stuff_vld,
  input logic             bit_out,
  input logic [IDX_W-1:0] bit_idx
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic             have_idx;
  logic [IDX_W-1:0] prev_idx;
  logic             prev_bit;
  logic [CW-1:0]    nout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_idx <= 1'b0;
      prev_idx <= '0;
      prev_bit <= 1'b0;
      nout     <= '0;
    end else if (frame_clr) begin
      have_idx <= 1'b0;
      nout     <= '0;
    end else if (bit_vld || stuff_vld) begin
      prev_bit <= bit_out;
      if (nout != FULL) nout <= nout + 1'b1;
      if (bit_vld) begin
        have_idx <= 1'b1;
        prev_idx <= bit_idx;
      end
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_vld && stuff_vld)); // R9
  AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(raw_vld) |-> !bit_vld && !stuff_vld); // R9
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_clr) |-> !bit_vld && !stuff_vld); // R6
  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && !have_idx |-> bit_idx == '0); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && have_idx |-> bit_idx == IDX_W'(prev_idx + 1'b1)); // R5
  AST_STUFF_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_vld && have_idx |-> bit_idx == IDX_W'(prev_idx + 1'b1)); // R2
  AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_vld |-> nout == FULL && bit_out != prev_bit); // R1
endmodule

bind can_destuff can_destuff_chk #(.IDX_W(IDX_W), .RUN_LEN(RUN_LEN)) u_chk (.*);

// File: tb/can_destuff_bench.sv
module can_destuff_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_vld = 1'b0, raw_bit = 1'b0, frame_clr = 1'b0, last_vld = 1'b0;
  logic [IW-1:0] last_idx = '0;
  logic bit_vld, stuff_vld, bit_out;
  logic [IW-1:0] bit_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_destuff #(.IDX_W(IW)) u_can_destuff (
    .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .raw_bit(raw_bit),
    .frame_clr(frame_clr), .last_vld(last_vld), .last_idx(last_idx),
    .bit_vld(bit_vld), .stuff_vld(stuff_vld), .bit_out(bit_out), .bit_idx(bit_idx)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one raw bit, sample outputs one falling edge later
  task automatic send(input logic b, output logic v, output logic s,
                      output logic o, output int idx);
    @(negedge clk);
    raw_vld = 1'b1; raw_bit = b;
    @(negedge clk);
    raw_vld = 1'b0;
    v = bit_vld; s = stuff_vld; o = bit_out; idx = int'(bit_idx);
  endtask

  task automatic expect_bit(string tag, logic b, int idx);
    logic v, s, o; int i;
    send(b, v, s, o, i);
    chk({tag, " vld"}, v, 1);
    chk({tag, " stuff"}, s, 0);
    chk({tag, " val"}, o, b);
    chk({tag, " idx"}, i, idx);
  endtask

  task automatic expect_stuff(string tag, logic b, int idx);
    logic v, s, o; int i;
    send(b, v, s, o, i);
    chk({tag, " vld"}, v, 0);
    chk({tag, " stuff"}, s, 1);
    chk({tag, " val"}, o, b);
    chk({tag, " idx"}, i, idx);
  endtask

  task automatic new_frame();
    @(negedge clk); frame_clr = 1'b1;
    @(negedge clk); frame_clr = 1'b0;
  endtask

  task automatic set_last(int l);
    @(negedge clk); last_vld = 1'b1; last_idx = IW'(l);
    @(negedge clk); last_vld = 1'b0; last_idx = IW'(100);
  endtask

  task automatic t_reset();
    chk("R10 bit_vld after reset", bit_vld, 0);
    chk("R10 stuff_vld after reset", stuff_vld, 0);
  endtask

  task automatic t_plain();
    logic [4:0] pat = 5'b10110;
    new_frame();
    for (int k = 0; k < 5; k++) expect_bit("R5 R9 plain", pat[4-k], k);
    @(negedge clk);
    chk("R9 no strobe no output", bit_vld | stuff_vld, 0);
  endtask

  task automatic t_stuff();
    new_frame();
    for (int k = 0; k < 5; k++) expect_bit("R1 zeros", 1'b0, k);
    expect_stuff("R1 R2 stuff 000001", 1'b1, 5);
    expect_bit("R2 idx held after stuff", 1'b1, 5);
    new_frame();
    for (int k = 0; k < 5; k++) expect_bit("R1 ones", 1'b1, k);
    expect_stuff("R1 stuff 111110", 1'b0, 5);
  endtask

  task automatic t_history();
    new_frame();
    for (int k = 0; k < 5; k++) expect_bit("R3 run", 1'b0, k);
    expect_stuff("R3 first stuff", 1'b1, 5);
    for (int k = 0; k < 4; k++) expect_bit("R3 ones", 1'b1, 5 + k);
    expect_stuff("R3 stuff bit counted in run", 1'b0, 9);
  endtask

  task automatic t_clear();
    logic v, s, o; int i;
    new_frame();
    for (int k = 0; k < 4; k++) expect_bit("R6 pre", 1'b1, k);
    new_frame();
    expect_bit("R4 R6 history cleared", 1'b1, 0);
    expect_bit("R4 too few raw bits", 1'b0, 1);
    @(negedge clk); frame_clr = 1'b1; raw_vld = 1'b1; raw_bit = 1'b1;
    @(negedge clk); frame_clr = 1'b0; raw_vld = 1'b0;
    chk("R6 strobe with clear dropped", bit_vld | stuff_vld, 0);
    expect_bit("R6 index restarts", 1'b0, 0);
  endtask

  task automatic run_to(int start_val, int upto, int base);
    for (int k = 0; k < upto; k++)
      expect_bit("R7 fill", logic'((start_val + k) % 2), base + k);
  endtask

  task automatic t_tail();
    new_frame();
    set_last(3);
    run_to(0, 15, 0);
    for (int k = 0; k < 5; k++) expect_bit("R7 run", 1'b1, 15 + k);
    expect_bit("R7 L+17 no destuff", 1'b0, 20);
    new_frame();
    set_last(3);
    run_to(1, 14, 0);
    for (int k = 0; k < 5; k++) expect_bit("R7 run b", 1'b1, 14 + k);
    expect_stuff("R7 R8 L+16 still destuffed", 1'b0, 19);
  endtask

  task automatic t_infinite();
    new_frame();
    run_to(0, 20, 0);
    for (int k = 0; k < 5; k++) expect_bit("R8 run", 1'b1, 20 + k);
    expect_stuff("R8 no threshold before last_vld", 1'b0, 25);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_stuff();
    t_history();
    t_clear();
    t_tail();
    t_infinite();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule